// File: doc/BRIEF.md
# Shared-Pin Serial I/O Port

This block is an eight-bit general-purpose I/O port whose pins are also used by on-chip serial peripherals. The upper nibble carries the synchronous serial port: bit 7 is slave select, bit 6 is serial clock, bit 5 is master-out/slave-in and bit 4 is master-in/slave-out. The lower nibble carries two asynchronous channels: bit 3 is transmit of channel 1, bit 2 is receive of channel 1, bit 1 is transmit of channel 0 and bit 0 is receive of channel 0. The block itself has no knowledge of these roles. Each peripheral claims a pin through a per-bit override enable and supplies the value to drive.

The CPU reaches two registers through a one-bit select. A select of 0 addresses the output latch, and a select of 1 addresses the direction register. Writes are accepted at any time and always land in all eight latch bits. What the pin shows depends on the override enable and on the direction bit. Reads of the latch register return one of two values per bit. For an input pin the read returns the synchronized pin level. For an output pin it returns whatever feeds that pin's driver.

The block has no sequencer. Its only state is the latch, the direction register and the synchronizer chain, so no states or transitions need naming.

Top module: `shared_pin_port`

## Requirements
- R1: While reset is asserted, the direction register clears to 0x00. Right after reset, with no override active, `pad_oe` is 0x00 and a read with `cpu_sel`=1 returns 0x00.
- R2: A write with `cpu_sel`=0 stores all eight bits of `cpu_wdata` in the latch, whatever the direction bits are at that moment. The stored value later appears on any pin that is switched to output.
- R3: Reset leaves the latch contents unchanged.
- R4: A bit with direction 1 and no override has `pad_oe` set and drives the latch bit on `pad_out`. A latch or direction write is visible on the pins in the cycle after the write strobe.
- R5: A bit with direction 0 and no override has `pad_oe` clear, so the pin is high-impedance.
- R6: For a bit whose direction is 0, a read with `cpu_sel`=0 returns `pad_in` through a two-flop synchronizer. A change on the pin shows in the read after two clock edges and not after one.
- R7: For a bit whose direction is 1, a read with `cpu_sel`=0 returns the driver input and never the pin level. The driver input is `per_out` when that bit's override is set, and the latch bit otherwise.
- R8: A set `per_oe` bit forces `pad_oe` high and drives `per_out` on that pin, whatever the direction bit. Latch writes made during the override change the latch but not the pin. The written value appears once the override drops, if the direction bit is 1.
- R9: A write with `cpu_sel`=1 loads the direction register, and a read with `cpu_sel`=1 returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 1 | Register select: 0 latch, 1 direction |
| cpu_wr | input | 1 | Write strobe, one cycle |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the selected register |
| per_oe | input | 8 | Per-pin peripheral override enable |
| per_out | input | 8 | Per-pin peripheral drive value |
| pad_in | input | 8 | Sampled pin levels (asynchronous) |
| pad_out | output | 8 | Driver input for each pin |
| pad_oe | output | 8 | Driver enable for each pin; 0 means high-impedance |

## Verification
The assertions run on every cycle and cover five points:
- a latch write lands on output pins the next cycle;
- clearing the direction register leaves only overridden pins driven;
- a latch write never disturbs a pin held by a steady override;
- reads of input pins match the pin level from two edges earlier;
- the direction register reads back what was written, and is zero right after reset.

Some properties need a particular history to observe, so only the bench scenarios show them. One is that the latch survives a reset pulse. Another is that a value written during an override appears once the override is released. The bench also sweeps every latch value, direction pattern and override mask, which shows that output bits read the driver input rather than a pin level held at the opposite value.

// File: rtl/shared_pin_port_pkg.sv
package shared_pin_port_pkg;
    typedef enum logic {
        REG_LATCH = 1'b0,
        REG_DIR   = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/spp_data_latch.sv
module spp_data_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Deliberately has no reset: the contents survive a reset pulse.
    always_ff @(posedge clk) begin
        if (wr_en) q <= wdata;
    end
endmodule

// File: rtl/spp_dir_reg.sv
module spp_dir_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= wdata;
    end
endmodule

// File: rtl/spp_sync.sv
module spp_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spp_drive_mux.sv
module spp_drive_mux #(
    parameter int W = 8
) (
    input  logic [W-1:0] latch_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] ovr_en,
    input  logic [W-1:0] ovr_val,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] drv_val,
    output logic [W-1:0] drv_en,
    output logic [W-1:0] read_val
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_comb begin
            // peripheral override wins over the direction bit
            drv_val[b]  = ovr_en[b] ? ovr_val[b] : latch_q[b];
            drv_en[b]   = ovr_en[b] | dir_q[b];
            read_val[b] = dir_q[b] ? drv_val[b] : pin_sync[b];
        end
    end
endmodule

// File: rtl/shared_pin_port.sv
module shared_pin_port #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_sel,
    input  logic             cpu_wr,
    input  logic [WIDTH-1:0] cpu_wdata,
    output logic [WIDTH-1:0] cpu_rdata,
    input  logic [WIDTH-1:0] per_oe,
    input  logic [WIDTH-1:0] per_out,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);
    import shared_pin_port_pkg::*;

    reg_sel_e         sel;
    logic             latch_we;
    logic             dir_we;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] read_val;

    assign sel      = reg_sel_e'(cpu_sel);
    assign latch_we = cpu_wr && (sel == REG_LATCH);
    assign dir_we   = cpu_wr && (sel == REG_DIR);

    spp_data_latch #(.W(WIDTH)) u_latch (
        .clk   (clk),
        .wr_en (latch_we),
        .wdata (cpu_wdata),
        .q     (latch_q)
    );

    spp_dir_reg #(.W(WIDTH)) u_dir (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (dir_we),
        .wdata (cpu_wdata),
        .q     (dir_q)
    );

    spp_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pin_sync)
    );

    spp_drive_mux #(.W(WIDTH)) u_mux (
        .latch_q  (latch_q),
        .dir_q    (dir_q),
        .ovr_en   (per_oe),
        .ovr_val  (per_out),
        .pin_sync (pin_sync),
        .drv_val  (pad_out),
        .drv_en   (pad_oe),
        .read_val (read_val)
    );

    always_comb begin
        unique case (sel)
            REG_LATCH: cpu_rdata = read_val;
            REG_DIR:   cpu_rdata = dir_q;
            default:   cpu_rdata = '0;
        endcase
    end
endmodule

// File: rtl/shared_pin_port_chk.sv
module shared_pin_port_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_sel,
    input logic             cpu_wr,
    input logic [WIDTH-1:0] cpu_wdata,
    input logic [WIDTH-1:0] cpu_rdata,
    input logic [WIDTH-1:0] per_oe,
    input logic [WIDTH-1:0] per_out,
    input logic [WIDTH-1:0] pad_in,
    input logic [WIDTH-1:0] pad_out,
    input logic [WIDTH-1:0] pad_oe
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd0) |-> (pad_oe == per_oe) && (!cpu_sel || cpu_rdata == '0));

    // R4
    latch_to_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_sel) |=> (((pad_out ^ $past(cpu_wdata)) & pad_oe & ~per_oe) == '0));

    // R5
    dir_clear_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_sel && cpu_wdata == '0) |=> (pad_oe == per_oe));

    // R8
    override_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_sel) |=>
        (((pad_out ^ $past(pad_out)) & per_oe & $past(per_oe) & ~(per_out ^ $past(per_out))) == '0));

    // R6
    input_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && !cpu_sel) |-> (((cpu_rdata ^ $past(pad_in, 2)) & ~pad_oe) == '0));

    // R9
    dir_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_sel) ##1 cpu_sel |-> (cpu_rdata == $past(cpu_wdata)));
endmodule

bind shared_pin_port shared_pin_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_sel   (cpu_sel),
    .cpu_wr    (cpu_wr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .per_oe    (per_oe),
    .per_out   (per_out),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
);

// File: tb/sim_shared_pin_port.sv
module sim_shared_pin_port;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_sel = 1'b0;
    logic         cpu_wr = 1'b0;
    logic [W-1:0] cpu_wdata = '0;
    logic [W-1:0] cpu_rdata;
    logic [W-1:0] per_oe = '0;
    logic [W-1:0] per_out = '0;
    logic [W-1:0] pad_in = 8'hA5;
    logic [W-1:0] pad_out;
    logic [W-1:0] pad_oe;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shared_pin_port #(.WIDTH(W), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .per_oe(per_oe),
        .per_out(per_out), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [W-1:0] val);
        cpu_sel = sel;
        cpu_wr = 1'b1;
        cpu_wdata = val;
        tick();
        cpu_wr = 1'b0;
    endtask

    initial begin
        logic [W-1:0] prev;
        logic [W-1:0] lat;
        logic [W-1:0] pin;
        logic [W-1:0] drv;
        @(negedge clk);
        tick();
        tick();
        rst_n = 1'b1;
        // R1: direction cleared, nothing driven
        chk("R1 pad_oe", pad_oe, 8'h00);
        cpu_sel = 1'b1;
        #1 chk("R1 dir read", cpu_rdata, 8'h00);
        cpu_sel = 1'b0;

        // R6: all inputs, latency of two edges
        tick(); tick(); tick();
        prev = 8'hA5;
        for (int v = 0; v < 256; v++) begin
            pad_in = v[W-1:0];
            tick();
            chk("R6 one edge", cpu_rdata, prev);
            tick();
            chk("R6 two edges", cpu_rdata, v[W-1:0]);
            prev = v[W-1:0];
        end

        // R2/R4/R7: every latch value on all-output port, pins held at opposite level
        wr(1'b1, 8'hFF);
        for (int v = 0; v < 256; v++) begin
            pad_in = ~v[W-1:0];
            wr(1'b0, v[W-1:0]);
            chk("R4 pad_out", pad_out, v[W-1:0]);
            chk("R4 pad_oe", pad_oe, 8'hFF);
            chk("R7 read driver", cpu_rdata, v[W-1:0]);
        end

        // R5/R7/R9/R2: every direction pattern
        lat = 8'h3C;
        pin = 8'h99;
        pad_in = pin;
        wr(1'b1, 8'h00);
        wr(1'b0, lat);
        tick(); tick();
        for (int d = 0; d < 256; d++) begin
            wr(1'b1, d[W-1:0]);
            chk("R9 dir read", cpu_rdata, d[W-1:0]);
            cpu_sel = 1'b0;
            #1;
            chk("R5 pad_oe", pad_oe, d[W-1:0]);
            chk("R2 pad_out", pad_out & d[W-1:0], lat & d[W-1:0]);
            chk("R7 mixed read", cpu_rdata, (lat & d[W-1:0]) | (pin & ~d[W-1:0]));
        end

        // R8: every override mask with dir=0x0F, latch=0x00
        wr(1'b1, 8'h0F);
        wr(1'b0, 8'h00);
        per_out = 8'hC3;
        for (int m = 0; m < 256; m++) begin
            per_oe = m[W-1:0];
            tick();
            drv = (8'hC3 & m[W-1:0]);
            chk("R8 pad_oe", pad_oe, m[W-1:0] | 8'h0F);
            chk("R8 pad_out", pad_out & pad_oe, drv & (m[W-1:0] | 8'h0F));
            chk("R7 override read", cpu_rdata, (drv & 8'h0F) | (pin & 8'hF0));
        end
        // R8: transmit bits overridden, latch write does not reach them
        per_oe = 8'h0A;
        tick();
        wr(1'b0, 8'hFF);
        chk("R8 write under override", pad_out & 8'h0F, 8'h05 | (8'hC3 & 8'h0A));
        per_oe = 8'h00;
        tick();
        chk("R8 latch after release", pad_out & 8'h0F, 8'h0F);

        // R3: latch survives reset
        wr(1'b0, 8'h5A);
        wr(1'b1, 8'h00);
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        chk("R1 pad_oe after reset", pad_oe, 8'h00);
        wr(1'b1, 8'hFF);
        cpu_sel = 1'b0;
        #1;
        chk("R3 latch kept pad", pad_out, 8'h5A);
        chk("R3 latch kept read", cpu_rdata, 8'h5A);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule